// File: doc/BRIEF.md
# SCSI Message-In Decoder

This block sits on the initiator side of a parallel SCSI link during the message-in phase. It takes the bytes a target sends, one at a time, under a valid/acknowledge handshake. It recognises the single-byte messages, the synchronous and wide negotiation requests, IDENTIFY and the simple-queue tag. It reports each recognised message to the host controller as a one-cycle event with a code. The parameters each message carries are held on output registers. The block also keeps a copy of the first byte of the most recent message.

When a message cannot be accepted, the block raises an attention request and queues a one-byte reply. The reply is a reject (0x07) or an abort-tag (0x0D). The offending byte is acknowledged only after it has been captured and decoded, so the attention request is already up when that byte is acknowledged. A reselection context comes in from the surrounding controller: the target number, the channel, whether a reselection is in progress and whether a tag must follow IDENTIFY. The block uses this context to build the nexus of the reconnecting command. It also uses it to flag a data or command phase that begins before IDENTIFY.

Top module: `msgin_decoder`

## Requirements
- R1: After reset, `evt_valid`, `atn_req` and `byte_ack` are low, `first_byte` is 0x00, and the next byte is decoded as the first byte of a message.
- R2: A byte presented with `byte_valid` high is captured on a clock edge. It is decoded on the next edge. `byte_ack` is high for exactly the one cycle after that second edge. Any event, field or reply caused by the byte is visible in that same cycle.
- R3: Event codes are 1 = command complete, 2 = save pointers, 3 = restore pointers, 4 = disconnect, 5 = reject received, 6 = sync negotiation, 7 = width negotiation, 8 = identify, 9 = tag accepted, 10 = reject sent, 11 = abort-tag sent and 12 = phase error. First bytes 0x00, 0x02, 0x03, 0x04 and 0x07 give events 1, 2, 3, 4 and 5.
- R4: `first_byte` holds the first byte of the most recent message. It does not change on later bytes of the same message.
- R5: A first byte of 0x01 starts an extended message. The next byte is the length and the byte after it is the code. The sequence 0x01, 0x03, 0x01, P, O gives event 6 on the O byte, with `sync_period` = P and `sync_offset` = O.
- R6: The sequence 0x01, 0x02, 0x03, W gives event 7 on the W byte, with `bus_width` = W.
- R7: An extended message whose code is neither 1 with length 3 nor 3 with length 2 is refused on its code byte. The block gives event 10, raises `atn_req` and sets `reply_byte` = 0x07.
- R8: A first byte with bit 7 set is IDENTIFY. If bits 6:3 are zero, the block gives event 8 and sets `nexus` = {`resel_chan`, `resel_target`, bits 2:0}. If any of bits 6:3 is set, the byte is refused as in R7.
- R9: With `tag_expected` high, the two bytes after an accepted IDENTIFY must be 0x20 and then a tag below 16. This gives event 9 with `tag_value` = tag. Any other byte at either position gives event 11, raises `atn_req` and queues 0x0D.
- R10: A first byte other than 0x00–0x04, 0x07 or one with bit 7 set is refused with event 10, `atn_req` and reply 0x07.
- R11: A one-cycle `info_phase` pulse while `resel_active` is high and no IDENTIFY has been accepted since `resel_active` rose gives event 12 in the following cycle. After an accepted IDENTIFY, the pulse gives no event.
- R12: `atn_req` and `reply_byte` hold until `reply_done` is pulsed, and `atn_req` falls on the following edge. A refusal that arrives while a reply is still pending leaves the queued byte unchanged.
- R13: `atn_req` is high no later than the cycle in which the refused byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Target presents a message byte; held until acknowledged |
| byte_data | input | 8 | Message byte |
| byte_ack | output | 1 | One-cycle acknowledge of the captured byte |
| resel_active | input | 1 | A reselection is in progress |
| resel_target | input | 4 | Reselecting target number |
| resel_chan | input | 1 | Channel of the reselection |
| tag_expected | input | 1 | A simple tag must follow IDENTIFY |
| info_phase | input | 1 | Pulse: target entered a data or command phase |
| reply_done | input | 1 | Pulse: the queued reply has been sent |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 4 | Event code (R3) |
| first_byte | output | 8 | First byte of the latest message |
| sync_period | output | 8 | Transfer period from sync negotiation |
| sync_offset | output | 8 | REQ/ACK offset from sync negotiation |
| bus_width | output | 8 | Width exponent from width negotiation |
| nexus | output | 8 | {channel, target, LUN} from IDENTIFY |
| tag_value | output | 8 | Accepted tag |
| atn_req | output | 1 | Attention request while a reply is queued |
| reply_byte | output | 8 | Queued reply message |

## Verification
Every byte-driven result is due one cycle after capture: the decode edge loads events, fields and the attention request together with `byte_ack`. The bench drives a byte at a falling edge and waits on falling edges for `byte_ack`. It expects the acknowledge at the second falling edge, and it samples all results on that same falling edge before it releases `byte_valid`. A phase error and the clearing of `atn_req` each take one edge, so the bench samples them at the falling edge that follows the pulse it drove.

// File: rtl/msgin_pkg.sv
// Package: shared byte constants, event codes and decoder states for the
// message-in decoder. Assumes 8-bit SCSI message bytes.
package msgin_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] MB_CMD_DONE  = 8'h00;
    localparam logic [7:0] MB_EXTENDED  = 8'h01;
    localparam logic [7:0] MB_SAVE_PTR  = 8'h02;
    localparam logic [7:0] MB_REST_PTR  = 8'h03;
    localparam logic [7:0] MB_DISCON    = 8'h04;
    localparam logic [7:0] MB_REJECT    = 8'h07;
    localparam logic [7:0] MB_ABORT_TAG = 8'h0D;
    localparam logic [7:0] MB_SIMPLE_Q  = 8'h20;

    localparam logic [7:0] EXT_SYNC_CODE  = 8'h01;
    localparam logic [7:0] EXT_SYNC_LEN   = 8'h03;
    localparam logic [7:0] EXT_WIDTH_CODE = 8'h03;
    localparam logic [7:0] EXT_WIDTH_LEN  = 8'h02;

    typedef enum logic [3:0] {
        EV_NONE       = 4'd0,
        EV_CMD_DONE   = 4'd1,
        EV_SAVE_PTR   = 4'd2,
        EV_REST_PTR   = 4'd3,
        EV_DISCON     = 4'd4,
        EV_PEER_REJ   = 4'd5,
        EV_SYNC_NEG   = 4'd6,
        EV_WIDTH_NEG  = 4'd7,
        EV_IDENT      = 4'd8,
        EV_TAG_OK     = 4'd9,
        EV_SENT_REJ   = 4'd10,
        EV_SENT_ABORT = 4'd11,
        EV_PHASE_ERR  = 4'd12
    } evt_e;

    typedef enum logic [2:0] {
        ST_FIRST,
        ST_EXT_LEN,
        ST_EXT_CODE,
        ST_SYNC_PER,
        ST_SYNC_OFF,
        ST_WIDTH,
        ST_TAG_MSG,
        ST_TAG_VAL
    } pst_e;

endpackage

// File: rtl/msgin_handshake.sv
// Byte handshake: captures one byte, gives the parser one decode cycle,
// then acknowledges. Assumes the sender holds byte_valid until byte_ack
// and drops it in the cycle of byte_ack.
module msgin_handshake
    import msgin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_fire,
    output logic              byte_ack
);

    typedef enum logic [1:0] {HS_IDLE, HS_DECODE, HS_ACK} hs_e;
    hs_e hs_q;

    // Purpose: advance capture -> decode -> acknowledge, one step per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q    <= HS_IDLE;
            rx_byte <= '0;
        end else begin
            case (hs_q)
                HS_IDLE:   if (byte_valid) begin
                               rx_byte <= byte_data;
                               hs_q    <= HS_DECODE;
                           end
                HS_DECODE: hs_q <= HS_ACK;
                default:   hs_q <= HS_IDLE;
            endcase
        end
    end

    assign rx_fire  = (hs_q == HS_DECODE);
    assign byte_ack = (hs_q == HS_ACK);

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack |=> !byte_ack);
    p_fire_then_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fire |=> byte_ack);

endmodule

// File: rtl/msgin_parser.sv
// Message parser: walks the byte stream of one message at a time, extracts
// negotiation, identify and tag fields, and flags refusals. Assumes one
// rx_fire strobe per byte and that info_phase never coincides with rx_fire.
module msgin_parser
    import msgin_pkg::*;
#(
    parameter int TARGET_W = 4,
    parameter int LUN_W    = 3,
    parameter int TAG_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_fire,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic                  tag_expected,
    input  logic                  resel_active,
    input  logic [TARGET_W-1:0]   resel_target,
    input  logic                  resel_chan,
    input  logic                  info_phase,
    output logic                  evt_valid,
    output evt_e                  evt_code,
    output logic [BYTE_W-1:0]     first_byte,
    output logic [BYTE_W-1:0]     sync_period,
    output logic [BYTE_W-1:0]     sync_offset,
    output logic [BYTE_W-1:0]     bus_width,
    output logic [NEXUS_W-1:0]    nexus,
    output logic [BYTE_W-1:0]     tag_value,
    output logic                  rej_req,
    output logic                  abort_req
);

    localparam int NEXUS_W = 1 + TARGET_W + LUN_W;

    pst_e              st_q, st_n;
    evt_e              ev;
    logic [BYTE_W-1:0] len_q;
    logic              ident_seen_q;
    logic              phase_err;

    // Purpose: decode the captured byte against the current parser state.
    always_comb begin
        st_n      = st_q;
        ev        = EV_NONE;
        rej_req   = 1'b0;
        abort_req = 1'b0;
        if (rx_fire) begin
            case (st_q)
                ST_FIRST: begin
                    if (rx_byte[BYTE_W-1]) begin
                        if (rx_byte[BYTE_W-2:LUN_W] != '0) begin
                            rej_req = 1'b1;
                        end else begin
                            ev   = EV_IDENT;
                            st_n = tag_expected ? ST_TAG_MSG : ST_FIRST;
                        end
                    end else begin
                        case (rx_byte)
                            MB_CMD_DONE: ev   = EV_CMD_DONE;
                            MB_SAVE_PTR: ev   = EV_SAVE_PTR;
                            MB_REST_PTR: ev   = EV_REST_PTR;
                            MB_DISCON:   ev   = EV_DISCON;
                            MB_REJECT:   ev   = EV_PEER_REJ;
                            MB_EXTENDED: st_n = ST_EXT_LEN;
                            default:     rej_req = 1'b1;
                        endcase
                    end
                end
                ST_EXT_LEN:  st_n = ST_EXT_CODE;
                ST_EXT_CODE: begin
                    if (rx_byte == EXT_SYNC_CODE && len_q == EXT_SYNC_LEN)
                        st_n = ST_SYNC_PER;
                    else if (rx_byte == EXT_WIDTH_CODE && len_q == EXT_WIDTH_LEN)
                        st_n = ST_WIDTH;
                    else begin
                        rej_req = 1'b1;
                        st_n    = ST_FIRST;
                    end
                end
                ST_SYNC_PER: st_n = ST_SYNC_OFF;
                ST_SYNC_OFF: begin ev = EV_SYNC_NEG;  st_n = ST_FIRST; end
                ST_WIDTH:    begin ev = EV_WIDTH_NEG; st_n = ST_FIRST; end
                ST_TAG_MSG: begin
                    if (rx_byte == MB_SIMPLE_Q) st_n = ST_TAG_VAL;
                    else begin
                        abort_req = 1'b1;
                        st_n      = ST_FIRST;
                    end
                end
                ST_TAG_VAL: begin
                    if (rx_byte[BYTE_W-1:TAG_W] == '0) ev = EV_TAG_OK;
                    else abort_req = 1'b1;
                    st_n = ST_FIRST;
                end
                default: st_n = ST_FIRST;
            endcase
            if (rej_req)   ev = EV_SENT_REJ;
            if (abort_req) ev = EV_SENT_ABORT;
        end
    end

    assign phase_err = info_phase && resel_active && !ident_seen_q;

    // Purpose: hold parser state, the extended length and the identify flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_FIRST;
            len_q        <= '0;
            ident_seen_q <= 1'b0;
        end else begin
            st_q <= st_n;
            if (rx_fire && st_q == ST_EXT_LEN) len_q <= rx_byte;
            if (!resel_active)         ident_seen_q <= 1'b0;
            else if (ev == EV_IDENT)   ident_seen_q <= 1'b1;
        end
    end

    // Purpose: register events and the extracted message fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid   <= 1'b0;
            evt_code    <= EV_NONE;
            first_byte  <= '0;
            sync_period <= '0;
            sync_offset <= '0;
            bus_width   <= '0;
            nexus       <= '0;
            tag_value   <= '0;
        end else begin
            evt_valid <= (ev != EV_NONE) || phase_err;
            evt_code  <= (ev != EV_NONE) ? ev : (phase_err ? EV_PHASE_ERR : EV_NONE);
            if (rx_fire && st_q == ST_FIRST)    first_byte  <= rx_byte;
            if (rx_fire && st_q == ST_SYNC_PER) sync_period <= rx_byte;
            if (ev == EV_SYNC_NEG)              sync_offset <= rx_byte;
            if (ev == EV_WIDTH_NEG)             bus_width   <= rx_byte;
            if (ev == EV_IDENT)
                nexus <= {resel_chan, resel_target, rx_byte[LUN_W-1:0]};
            if (ev == EV_TAG_OK)                tag_value   <= rx_byte;
        end
    end

    p_evt_has_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_code != EV_NONE);
    p_phase_err_ctx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_PHASE_ERR) |-> $past(resel_active));
    p_tag_after_ident_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fire && st_q == ST_TAG_VAL) |-> $past(st_q == ST_TAG_MSG, 3));

endmodule

// File: rtl/msgin_reply.sv
// Reply queue: holds one outgoing reject or abort-tag byte and the
// attention request until the message-out side reports it sent.
// Assumes at most one of rej_req / abort_req is high in a cycle.
module msgin_reply
    import msgin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rej_req,
    input  logic              abort_req,
    input  logic              reply_done,
    output logic              atn_req,
    output logic [BYTE_W-1:0] reply_byte
);

    // Purpose: accept the first refusal, keep it until reply_done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atn_req    <= 1'b0;
            reply_byte <= MB_REJECT;
        end else if (atn_req) begin
            if (reply_done) atn_req <= 1'b0;
        end else if (rej_req || abort_req) begin
            atn_req    <= 1'b1;
            reply_byte <= abort_req ? MB_ABORT_TAG : MB_REJECT;
        end
    end

    p_reply_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (atn_req && !reply_done) |=> (atn_req && $stable(reply_byte)));
    p_reply_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        atn_req |-> (reply_byte == MB_REJECT || reply_byte == MB_ABORT_TAG));

endmodule

// File: rtl/msgin_decoder.sv
// Top of the message-in decoder: handshake, parser and reply queue.
// Assumes byte_valid is held until byte_ack and that reply_done is a
// single-cycle pulse from the message-out side.
module msgin_decoder
    import msgin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       byte_ack,
    input  logic       resel_active,
    input  logic [3:0] resel_target,
    input  logic       resel_chan,
    input  logic       tag_expected,
    input  logic       info_phase,
    input  logic       reply_done,
    output logic       evt_valid,
    output logic [3:0] evt_code,
    output logic [7:0] first_byte,
    output logic [7:0] sync_period,
    output logic [7:0] sync_offset,
    output logic [7:0] bus_width,
    output logic [7:0] nexus,
    output logic [7:0] tag_value,
    output logic       atn_req,
    output logic [7:0] reply_byte
);

    localparam int TARGET_W = 4;
    localparam int LUN_W    = 3;
    localparam int TAG_W    = 4;

    logic [BYTE_W-1:0] rx_byte;
    logic              rx_fire;
    logic              rej_req, abort_req;
    evt_e              evt_q;

    msgin_handshake u_hs (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .rx_byte(rx_byte), .rx_fire(rx_fire), .byte_ack(byte_ack)
    );

    msgin_parser #(.TARGET_W(TARGET_W), .LUN_W(LUN_W), .TAG_W(TAG_W)) u_parse (
        .clk(clk), .rst_n(rst_n),
        .rx_fire(rx_fire), .rx_byte(rx_byte),
        .tag_expected(tag_expected), .resel_active(resel_active),
        .resel_target(resel_target), .resel_chan(resel_chan),
        .info_phase(info_phase),
        .evt_valid(evt_valid), .evt_code(evt_q),
        .first_byte(first_byte), .sync_period(sync_period),
        .sync_offset(sync_offset), .bus_width(bus_width),
        .nexus(nexus), .tag_value(tag_value),
        .rej_req(rej_req), .abort_req(abort_req)
    );

    msgin_reply u_reply (
        .clk(clk), .rst_n(rst_n),
        .rej_req(rej_req), .abort_req(abort_req),
        .reply_done(reply_done),
        .atn_req(atn_req), .reply_byte(reply_byte)
    );

    assign evt_code = evt_q;

    p_evt_with_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_q != EV_PHASE_ERR) |-> byte_ack);
    p_atn_by_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_req || abort_req) |=> (atn_req && byte_ack));

endmodule

// File: tb/tb_msgin_decoder.sv
module tb_msgin_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_ack;
    logic       resel_active = 1'b0;
    logic [3:0] resel_target = 4'hA;
    logic       resel_chan = 1'b1;
    logic       tag_expected = 1'b0;
    logic       info_phase = 1'b0;
    logic       reply_done = 1'b0;
    logic       evt_valid;
    logic [3:0] evt_code;
    logic [7:0] first_byte, sync_period, sync_offset, bus_width;
    logic [7:0] nexus, tag_value, reply_byte;
    logic       atn_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    msgin_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ack(byte_ack),
        .resel_active(resel_active), .resel_target(resel_target),
        .resel_chan(resel_chan), .tag_expected(tag_expected),
        .info_phase(info_phase), .reply_done(reply_done),
        .evt_valid(evt_valid), .evt_code(evt_code),
        .first_byte(first_byte), .sync_period(sync_period),
        .sync_offset(sync_offset), .bus_width(bus_width),
        .nexus(nexus), .tag_value(tag_value),
        .atn_req(atn_req), .reply_byte(reply_byte)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected event as the bench sees it: 0 means no strobe.
    function automatic int seen_evt();
        return evt_valid ? int'(evt_code) : 0;
    endfunction

    int ack_wait;

    // Drive one byte and stop at the falling edge where byte_ack is high.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_data  = b;
        byte_valid = 1'b1;
        ack_wait   = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ack_wait++;
            if (byte_ack) break;
        end
        byte_valid = 1'b0;
    endtask

    task automatic pulse_reply_done();
        @(negedge clk);
        reply_done = 1'b1;
        @(negedge clk);
        reply_done = 1'b0;
    endtask

    // {byte, event, atn, reply}
    localparam int NV = 24;
    localparam logic [20:0] VEC [NV] = '{
        {8'h00, 4'd1,  1'b0, 8'h00},
        {8'h02, 4'd2,  1'b0, 8'h00},
        {8'h03, 4'd3,  1'b0, 8'h00},
        {8'h04, 4'd4,  1'b0, 8'h00},
        {8'h07, 4'd5,  1'b0, 8'h00},
        {8'h01, 4'd0,  1'b0, 8'h00},
        {8'h03, 4'd0,  1'b0, 8'h00},
        {8'h01, 4'd0,  1'b0, 8'h00},
        {8'h19, 4'd0,  1'b0, 8'h00},
        {8'h0C, 4'd6,  1'b0, 8'h00},
        {8'h01, 4'd0,  1'b0, 8'h00},
        {8'h02, 4'd0,  1'b0, 8'h00},
        {8'h03, 4'd0,  1'b0, 8'h00},
        {8'h01, 4'd7,  1'b0, 8'h00},
        {8'h01, 4'd0,  1'b0, 8'h00},
        {8'h02, 4'd0,  1'b0, 8'h00},
        {8'h01, 4'd10, 1'b1, 8'h07},
        {8'h01, 4'd0,  1'b0, 8'h00},
        {8'h03, 4'd0,  1'b0, 8'h00},
        {8'h05, 4'd10, 1'b1, 8'h07},
        {8'h05, 4'd10, 1'b1, 8'h07},
        {8'h85, 4'd8,  1'b0, 8'h00},
        {8'hC0, 4'd10, 1'b1, 8'h07},
        {8'h88, 4'd10, 1'b1, 8'h07}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!evt_valid && !atn_req && !byte_ack, "R1 idle outputs",
            {evt_valid, atn_req, byte_ack}, 0);
        chk(first_byte == 8'h00, "R1 first_byte", first_byte, 0);
        rst_n = 1'b1;

        // Table walk: R3 R5 R6 R7 R8 R10 R13, with R2 timing and R12 release
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][20:13]);
            chk(ack_wait == 2, "R2 ack timing", ack_wait, 2);
            chk(seen_evt() == int'(VEC[v][12:9]), "R3 event code",
                seen_evt(), VEC[v][12:9]);
            chk(atn_req == VEC[v][8], "R13 atn with ack", atn_req, VEC[v][8]);
            if (VEC[v][8]) begin
                chk(reply_byte == VEC[v][7:0], "R7 reply byte",
                    reply_byte, VEC[v][7:0]);
                pulse_reply_done();
                chk(!atn_req, "R12 atn released", atn_req, 0);
            end
            if (v == 9) begin
                chk(sync_period == 8'h19, "R5 period", sync_period, 8'h19);
                chk(sync_offset == 8'h0C, "R5 offset", sync_offset, 8'h0C);
                chk(first_byte == 8'h01, "R4 first byte kept", first_byte, 8'h01);
            end
            if (v == 13) chk(bus_width == 8'h01, "R6 width", bus_width, 8'h01);
            if (v == 21) begin
                chk(nexus == 8'hD5, "R8 nexus", nexus, 8'hD5);
                chk(first_byte == 8'h85, "R4 first byte", first_byte, 8'h85);
            end
        end
        // R2: ack is a single cycle
        @(negedge clk);
        chk(!byte_ack, "R2 ack single cycle", byte_ack, 0);

        // R9: tagged reconnection, good tag
        tag_expected = 1'b1;
        send(8'h81);
        chk(seen_evt() == 8, "R9 identify", seen_evt(), 8);
        send(8'h20);
        chk(seen_evt() == 0, "R9 tag message", seen_evt(), 0);
        send(8'h05);
        chk(seen_evt() == 9 && tag_value == 8'h05, "R9 tag accepted",
            {seen_evt(), tag_value}, {8'd9, 8'h05});
        // R9: tag out of range
        send(8'h81);
        send(8'h20);
        send(8'h35);
        chk(seen_evt() == 11 && atn_req && reply_byte == 8'h0D, "R9 abort range",
            {seen_evt(), atn_req, reply_byte}, {8'd11, 1'b1, 8'h0D});
        pulse_reply_done();
        // R9: wrong message after identify
        send(8'h81);
        send(8'h23);
        chk(seen_evt() == 11 && reply_byte == 8'h0D, "R9 abort not simple",
            {seen_evt(), reply_byte}, {8'd11, 8'h0D});
        pulse_reply_done();

        // R12: pending reject keeps its byte over a later abort
        send(8'h05);
        send(8'h81);
        send(8'h21);
        chk(seen_evt() == 11 && atn_req && reply_byte == 8'h07, "R12 first reply kept",
            {seen_evt(), atn_req, reply_byte}, {8'd11, 1'b1, 8'h07});
        pulse_reply_done();
        chk(!atn_req, "R12 atn released", atn_req, 0);
        tag_expected = 1'b0;

        // R11: phase before identify during reselection
        @(negedge clk);
        resel_active = 1'b1;
        @(negedge clk);
        info_phase = 1'b1;
        @(negedge clk);
        info_phase = 1'b0;
        chk(seen_evt() == 12, "R11 phase error", seen_evt(), 12);
        send(8'h82);
        chk(seen_evt() == 8 && nexus == 8'hD2, "R8 nexus reselect",
            {seen_evt(), nexus}, {8'd8, 8'hD2});
        @(negedge clk);
        info_phase = 1'b1;
        @(negedge clk);
        info_phase = 1'b0;
        chk(seen_evt() == 0, "R11 no error after identify", seen_evt(), 0);
        resel_active = 1'b0;

        // R1: reset mid-message returns to the first-byte state
        send(8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(first_byte == 8'h00 && !atn_req, "R1 reset again",
            {first_byte, atn_req}, 0);
        send(8'h04);
        chk(seen_evt() == 4, "R1 decodes first byte after reset", seen_evt(), 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule